// File: doc/BRIEF.md
# Boot Region Page Range Checker

This block decides whether a flash page number lies inside one of a handful of special boot regions. In these regions the spare bytes are stored without error-correction protection. Software first loads a small table through a write port: each entry holds a start page and a length in pages. It then writes how many entries are valid. After that, page numbers are presented on a query port. Each query is answered with a boot/not-boot flag and a one-cycle done strobe.

The search is sequential and takes one cycle per entry examined. It is tuned for the common case, a page far past every boot region. The highest valid entry is examined first. A page strictly beyond that entry's end is rejected after a single cycle. Otherwise the remaining entries are walked from the next-lower index down to index 0, and the walk stops at the first match.

Top module: `boot_region_checker`

## Requirements
- R1: After reset, busy, done and is_boot are 0 and the valid-entry count is 0.
- R2: An entry covers page p when start <= p < start + length, where the end is computed one bit wider than a page, so a range that runs past the largest page number does not wrap around.
- R3: With a valid-entry count of 0, a query returns not-boot, with done one cycle after the accepting cycle.
- R4: The highest valid entry (index count-1) is examined first. If the page is strictly greater than that entry's end, the answer is not-boot after exactly one cycle, even when a lower entry would cover the page.
- R5: A page equal to the highest entry's end is not rejected early. It goes on to the backward walk, where a lower entry may still match it.
- R6: The walk examines indices count-2 down to 0 at one entry per cycle. A first match found at index i < count-1 finishes count-i cycles after acceptance. No match at all finishes count cycles after acceptance.
- R7: done is a single-cycle pulse. busy is high from the cycle after acceptance until done. is_boot changes only when done rises and holds its value while idle.
- R8: A query presented while busy is high is ignored. It changes neither the result nor the timing of the query in progress, and it produces no extra done.
- R9: Writing a count greater than MAX_ENT stores MAX_ENT.
- R10: A table write (tbl_we) sets the start and length of entry tbl_idx. Entries at or above the valid count never affect a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Write one table entry |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_start | input | PAGE_W | First page of the region |
| tbl_len | input | PAGE_W | Region length in pages |
| cnt_we | input | 1 | Write the valid-entry count |
| cnt_val | input | CNT_W | New valid-entry count |
| q_valid | input | 1 | Query request, accepted when busy is low |
| q_page | input | PAGE_W | Page number to classify |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| is_boot | output | 1 | 1 when the last query hit a boot region |

## Verification
Every page in a window is swept against several tables: an empty table, disjoint regions, overlapping regions with a short count, a full table written with an oversized count, and a region that crosses the top of the page space. The bench compares both the flag and the latency in cycles against an arithmetic model. Latency is what separates an early reject from a full walk, and it also reveals a walk in the wrong order. Pages exactly at the highest region's end, pages one past it that a lower region still covers, and stray queries injected while busy isolate the early-exit boundary and the ignore rule.

// File: rtl/boot_region_checker.sv
module boot_region_checker #(
  parameter int PAGE_W  = 16,
  parameter int MAX_ENT = 8,
  localparam int IDX_W  = (MAX_ENT > 1) ? $clog2(MAX_ENT) : 1,
  localparam int CNT_W  = $clog2(MAX_ENT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [PAGE_W-1:0] tbl_start,
  input  logic [PAGE_W-1:0] tbl_len,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              q_valid,
  input  logic [PAGE_W-1:0] q_page,
  output logic              busy,
  output logic              done,
  output logic              is_boot
);

  logic [PAGE_W-1:0] start_q [MAX_ENT];
  logic [PAGE_W-1:0] len_q   [MAX_ENT];
  logic [CNT_W-1:0]  count_q;
  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  ptr_q;
  logic              first_q, empty_q, busy_q, done_q, boot_q;

  wire              accept = q_valid && !busy_q;
  wire [PAGE_W:0]   lo_w   = {1'b0, start_q[ptr_q]};
  wire [PAGE_W:0]   end_w  = lo_w + {1'b0, len_q[ptr_q]};
  wire [PAGE_W:0]   pg_w   = {1'b0, page_q};
  wire              hit    = !empty_q && (pg_w >= lo_w) && (pg_w < end_w);
  wire              beyond = first_q && (pg_w > end_w);
  wire              finish = empty_q || beyond || hit || (ptr_q == '0);

  assign busy    = busy_q;
  assign done    = done_q;
  assign is_boot = boot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_ENT; i++) begin
        start_q[i] <= '0;
        len_q[i]   <= '0;
      end
      count_q <= '0;
    end else begin
      if (tbl_we) begin
        start_q[tbl_idx] <= tbl_start;
        len_q[tbl_idx]   <= tbl_len;
      end
      if (cnt_we)
        count_q <= (cnt_val > CNT_W'(MAX_ENT)) ? CNT_W'(MAX_ENT) : cnt_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      boot_q  <= 1'b0;
      first_q <= 1'b0;
      empty_q <= 1'b0;
      page_q  <= '0;
      ptr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        page_q  <= q_page;
        first_q <= 1'b1;
        empty_q <= (count_q == '0);
        ptr_q   <= IDX_W'(count_q - CNT_W'(1));
      end else if (busy_q) begin
        if (finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          boot_q <= hit;
        end else begin
          ptr_q   <= ptr_q - IDX_W'(1);
          first_q <= 1'b0;
        end
      end
    end
  end

endmodule

module boot_region_checker_sva #(
  parameter int MAX_ENT = 8,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             q_valid,
  input logic             busy,
  input logic             done,
  input logic             is_boot,
  input logic [CNT_W-1:0] count
);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) busy && !done |=> busy || done);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !q_valid |=> $stable(is_boot) && !done);

  // R3
  empty_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !busy && count == '0 |=> busy ##1 (done && !is_boot));

  // R9
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) count <= CNT_W'(MAX_ENT));

endmodule

bind boot_region_checker boot_region_checker_sva #(.MAX_ENT(MAX_ENT), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .busy(busy),
  .done(done), .is_boot(is_boot), .count(count_q)
);

// File: tb/boot_region_checker_tb.sv
module boot_region_checker_tb;
  localparam int PW = 16;
  localparam int NE = 8;

  logic          clk = 0, rst_n = 0;
  logic          tbl_we = 0, cnt_we = 0, q_valid = 0;
  logic [2:0]    tbl_idx = '0;
  logic [PW-1:0] tbl_start = '0, tbl_len = '0, q_page = '0;
  logic [3:0]    cnt_val = '0;
  logic          busy, done, is_boot;

  int total = 0, bad = 0;
  int rs [NE];
  int rl [NE];
  int rcnt = 0;

  always #10 clk = ~clk;

  boot_region_checker #(.PAGE_W(PW), .MAX_ENT(NE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_start(tbl_start), .tbl_len(tbl_len), .cnt_we(cnt_we), .cnt_val(cnt_val),
    .q_valid(q_valid), .q_page(q_page), .busy(busy), .done(done), .is_boot(is_boot)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_entry(input int i, input int s, input int l);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 3'(i); tbl_start = PW'(s); tbl_len = PW'(l);
    rs[i] = s; rl[i] = l;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic wr_count(input int c);
    @(negedge clk);
    cnt_we = 1; cnt_val = 4'(c);
    rcnt = (c > NE) ? NE : c;   // R9 clamp
    @(negedge clk);
    cnt_we = 0;
  endtask

  function automatic void model(input int pg, output bit b, output int cyc, output string tag);
    int last, e;
    b = 0; cyc = 1;
    if (rcnt == 0) begin tag = "R3"; return; end
    last = rcnt - 1;
    e = rs[last] + rl[last];
    if (pg > e) begin tag = "R4"; return; end
    if (pg >= rs[last] && pg < e) begin b = 1; tag = "R2"; return; end
    for (int i = rcnt - 2; i >= 0; i--) begin
      cyc = rcnt - i;
      if (pg >= rs[i] && pg < rs[i] + rl[i]) begin
        b = 1;
        tag = (pg == e) ? "R5" : "R6";
        return;
      end
    end
    cyc = rcnt;
    tag = (pg == e) ? "R5" : "R6";
  endfunction

  task automatic query(input int pg, input bit poke);
    bit eb; int ec, n; string tg;
    model(pg, eb, ec, tg);
    @(negedge clk);
    q_valid = 1; q_page = PW'(pg);
    @(negedge clk);
    q_valid = 0;
    chk(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
    if (poke) begin q_valid = 1; q_page = PW'(pg) ^ 16'h00FF; end
    n = 0;
    do begin
      @(negedge clk);
      q_valid = 0;
      n++;
    end while (!done && n < 20);
    chk(n == ec, {tg, " latency"}, n, ec);
    chk(is_boot == eb, {tg, " result"}, int'(is_boot), int'(eb));
    @(negedge clk);
    chk(!done && !busy && is_boot == eb, poke ? "R8 ignored query" : "R7 pulse/hold",
        {done, busy, is_boot}, {2'b00, eb});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) begin rs[i] = 0; rl[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !is_boot, "R1 reset outputs", {busy, done, is_boot}, 0);
    query(0, 0);   // R1: count 0 after reset

    // empty table with stored entries: R3, R10
    wr_entry(0, 5, 10);
    wr_entry(1, 20, 5);
    wr_count(0);
    for (int p = 0; p < 40; p++) query(p, p % 7 == 3);

    // disjoint regions: R2, R4, R6
    wr_entry(0, 10, 5);
    wr_entry(1, 20, 4);
    wr_entry(2, 30, 6);
    wr_entry(3, 0, 80);  // beyond count, R10
    wr_count(3);
    for (int p = 0; p < 80; p++) query(p, p % 7 == 1);

    // overlap and end boundary: R4 early reject, R5 fall-through
    wr_entry(0, 50, 10);
    wr_entry(1, 40, 10);
    wr_entry(2, 0, 200);
    wr_count(2);
    query(50, 0);  // R5 equals last end, lower entry matches
    query(51, 0);  // R4 rejected early though entry 0 covers it
    for (int p = 35; p < 65; p++) query(p, p % 5 == 0);

    // full table, oversized count: R9, zero-length entry
    for (int i = 0; i < NE; i++) wr_entry(i, i * 8, (i == 3) ? 0 : 3);
    wr_count(12);
    for (int p = 0; p < 80; p++) query(p, p % 9 == 2);

    // range across top of page space: R2 no wrap
    wr_entry(0, 16'hFFF0, 16'h0020);
    wr_count(1);
    query(16'hFFFF, 0);
    query(16'hFFEF, 0);
    query(0, 0);
    query(5, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule